// File: doc/BRIEF.md
# CPU-Priority DMA Request Gate

This block stands between the per-channel DMA request lines and the DMA engine. It decides, channel by channel, whether a pending transfer request may go ahead or must wait because the CPU is currently running at an equal or higher priority. It holds a 3-bit CPU priority level, a two-bit control register (gating enable and automatic update), and one 3-bit priority per DMA channel. All of these are written through a simple address/data write port.

The CPU level can be set in two ways. Software can write it directly. Or, when automatic update is on, it follows the interrupt mask bits. How it follows them depends on the interrupt control mode. In the single-mask-bit mode, the level is either zero or four. In the three-bit-mask mode, the level copies the mask. The gated request outputs are combinational from the raw requests and the registered priority state. The current CPU level can be read back on a dedicated output.

Register addresses on `wr_addr`: 0 = control, with bit 0 as gating enable and bit 1 as auto-update. 1 = CPU priority, using bits 2:0. 2+k = priority of channel k, using bits 2:0. On `irq_mode`, 0 selects the single-mask-bit mode and 1 selects the three-bit-mask mode.

Top module: `dma_prio_gate`

## Requirements
- R1: After reset, gating is disabled, auto-update is off, the CPU priority reads 0, and every channel priority is 0. Enabling gating with no other write therefore masks every channel.
- R2: While the gating enable (control bit 0) is 0, `req_gated` equals `req_raw` whatever the priority values are.
- R3: While the gating enable is 1, channel k's gated request is high exactly when its raw request is high and its 3-bit priority is strictly greater than the CPU priority. For example, CPU level 4 blocks channel levels 0, 3 and 4 and passes level 5.
- R4: With auto-update (control bit 1) set and `irq_mode` = 0, the CPU priority becomes 4 one clock after `imask[0]` is 1, and becomes 0 one clock after `imask[0]` is 0.
- R5: With auto-update set and `irq_mode` = 1, the CPU priority becomes the value of `imask[2:0]` one clock after it is presented.
- R6: With auto-update set, a write to the CPU priority address has no effect on the CPU priority.
- R7: With auto-update clear, the CPU priority keeps the last value it held and ignores `imask`. A write to address 1 loads `wr_data` on the next clock.
- R8: A write to a channel's priority address changes only that channel's priority. Each channel is gated on its own priority alone.
- R9: A change on `req_raw` reaches `req_gated` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (0 control, 1 CPU priority, 2+k channel k) |
| wr_data | input | 3 | Write data |
| irq_mode | input | 1 | Interrupt control mode: 0 single mask bit, 1 three-bit mask |
| imask | input | 3 | Interrupt mask bits (bit 0 is the single mask bit in mode 0) |
| req_raw | input | NCH | Raw transfer requests, one per channel |
| req_gated | output | NCH | Requests allowed through to the DMA engine |
| cpu_prio | output | 3 | Current CPU priority level |

## Verification
A corrupted CPU priority register shows up on the `cpu_prio` readback at the next sampling point. It also shows up as wrong masking on any channel whose priority lies between the true and the false level, in the same cycle. A channel priority register that is wrong, or that is disturbed by a write to a different address, is seen only when gating is enabled and the CPU level sits at the boundary around that channel's level. For that reason the vectors put channel priorities equal to, one above and one below the CPU level. A wrong mode mapping shows up one clock after the mask input changes.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int PW = 3;
  typedef logic [PW-1:0] prio_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CPU   = 1;
  localparam int CH_BASE    = 2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AUTO_BIT = 1;

  localparam prio_t MODE0_HIGH = 3'b100;
  localparam prio_t PRIO_ZERO  = 3'b000;
endpackage

// File: rtl/dpg_rst_sync.sv
module dpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dpg_ctrl_regs.sv
module dpg_ctrl_regs
  import dpg_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  prio_t         wr_data,
  input  logic          irq_mode,
  input  prio_t         imask,
  output logic          gate_en,
  output prio_t         cpu_prio
);
  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_CPU  = AW'(ADDR_CPU);

  logic  en_q, en_d, auto_q, auto_d;
  prio_t cpu_q, cpu_d, mask_level;
  logic  ctrl_we, cpu_we, cpu_ce;

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign cpu_we  = wr_en && (wr_addr == A_CPU);
  // Register is clocked every cycle while tracking, otherwise only on a write.
  assign cpu_ce  = auto_q || cpu_we;

  // Mode mapping from interrupt mask to CPU level.
  always_comb begin
    if (irq_mode) mask_level = imask;
    else          mask_level = imask[0] ? MODE0_HIGH : PRIO_ZERO;
  end

  always_comb begin
    en_d   = wr_data[CTRL_EN_BIT];
    auto_d = wr_data[CTRL_AUTO_BIT];
    cpu_d  = auto_q ? mask_level : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      cpu_q  <= PRIO_ZERO;
    end else begin
      if (ctrl_we) begin
        en_q   <= en_d;
        auto_q <= auto_d;
      end
      if (cpu_ce) cpu_q <= cpu_d;
    end
  end

  assign gate_en  = en_q;
  assign cpu_prio = cpu_q;

  // R4: mode 0 tracking
  p_mode0_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && !irq_mode) |=> (cpu_prio == ($past(imask[0]) ? MODE0_HIGH : PRIO_ZERO)));

  // R5: mode 2 tracking
  p_mode2_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && irq_mode) |=> (cpu_prio == $past(imask)));

  // R7: software-held level is stable without a write
  p_hold_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_q && !cpu_we) |=> $stable(cpu_prio));

  // R7: software write lands next cycle
  p_sw_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_q && cpu_we) |=> (cpu_prio == $past(wr_data)));
endmodule

// File: rtl/dpg_chan_regs.sv
module dpg_chan_regs
  import dpg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  prio_t            wr_data,
  output prio_t [NCH-1:0]  chan_prio
);
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    localparam logic [AW-1:0] MY_ADDR = AW'(k + CH_BASE);
    logic  we;
    prio_t prio_q, prio_d;

    assign we     = wr_en && (wr_addr == MY_ADDR);
    assign prio_d = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prio_q <= PRIO_ZERO;
      else if (we) prio_q <= prio_d;
    end

    assign chan_prio[k] = prio_q;

    // R8: only a write to this channel's address changes it
    p_chan_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == MY_ADDR) |=> $stable(chan_prio[k]));
  end
endmodule

// File: rtl/dpg_req_gate.sv
module dpg_req_gate
  import dpg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_en,
  input  prio_t           cpu_prio,
  input  prio_t [NCH-1:0] chan_prio,
  input  logic [NCH-1:0]  req_raw,
  output logic [NCH-1:0]  req_gated
);
  logic [NCH-1:0] above_cpu;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    assign above_cpu[k] = chan_prio[k] > cpu_prio;
    assign req_gated[k] = req_raw[k] & (~gate_en | above_cpu[k]);
  end

  // R2: bypass while gating is off
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (req_gated == req_raw));

  // R3: a gated request never appears without its raw request
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_gated & ~req_raw) == '0);
endmodule

// File: rtl/dma_prio_gate.sv
module dma_prio_gate
  import dpg_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH + CH_BASE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [2:0]     wr_data,
  input  logic           irq_mode,
  input  logic [2:0]     imask,
  input  logic [NCH-1:0] req_raw,
  output logic [NCH-1:0] req_gated,
  output logic [2:0]     cpu_prio
);
  logic            rst_n_sync;
  logic            gate_en;
  prio_t           cpu_level;
  prio_t [NCH-1:0] chan_prio;

  dpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dpg_ctrl_regs #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_mode (irq_mode),
    .imask    (imask),
    .gate_en  (gate_en),
    .cpu_prio (cpu_level)
  );

  dpg_chan_regs #(.NCH(NCH), .AW(AW)) u_chan (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .chan_prio (chan_prio)
  );

  dpg_req_gate #(.NCH(NCH)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .gate_en   (gate_en),
    .cpu_prio  (cpu_level),
    .chan_prio (chan_prio),
    .req_raw   (req_raw),
    .req_gated (req_gated)
  );

  assign cpu_prio = cpu_level;
endmodule

// File: tb/dma_prio_gate_test.sv
module dma_prio_gate_test;
  localparam int NCH = 4;
  localparam int AW  = 3;
  localparam int WATCHDOG_CYCLES = 20000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [2:0]     wr_data;
  logic           irq_mode;
  logic [2:0]     imask;
  logic [NCH-1:0] req_raw;
  logic [NCH-1:0] req_gated;
  logic [2:0]     cpu_prio;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_prio_gate #(.NCH(NCH)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq_mode  (irq_mode),
    .imask     (imask),
    .req_raw   (req_raw),
    .req_gated (req_gated),
    .cpu_prio  (cpu_prio)
  );

  // {en, cpu, p3, p2, p1, p0, raw, expected}
  localparam int NVEC = 10;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 4'hF, 4'hF},
    {1'b1, 3'd4, 3'd4, 3'd5, 3'd3, 3'd0, 4'hF, 4'h4},
    {1'b1, 3'd0, 3'd0, 3'd7, 3'd1, 3'd0, 4'hF, 4'h6},
    {1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 4'hF, 4'h0},
    {1'b1, 3'd6, 3'd5, 3'd7, 3'd6, 3'd7, 4'h5, 4'h5},
    {1'b1, 3'd3, 3'd4, 3'd4, 3'd4, 3'd4, 4'hA, 4'hA},
    {1'b0, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0, 4'h9, 4'h9},
    {1'b1, 3'd2, 3'd7, 3'd1, 3'd2, 3'd3, 4'hF, 4'h9},
    {1'b1, 3'd5, 3'd5, 3'd5, 3'd6, 3'd6, 4'h0, 4'h0},
    {1'b1, 3'd1, 3'd2, 3'd0, 3'd1, 3'd2, 4'hF, 4'h9}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [2:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_mode = 1'b0; imask = 3'b000; req_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    req_raw = 4'hF; #1;
    check("R1 cpu_prio after reset", {1'b0, cpu_prio}, 4'h0);
    check("R1 bypass after reset", req_gated, 4'hF);
    wr(0, 3'b001);
    #1;
    check("R1 channel priorities zero (all masked)", req_gated, 4'h0);

    // R2, R3, R8: vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(0, {2'b00, VEC[i][23]});
      wr(1, VEC[i][22:20]);
      for (int k = 0; k < NCH; k++) wr(2 + k, VEC[i][8 + 3*k +: 3]);
      req_raw = VEC[i][7:4]; #1;
      check(VEC[i][23] ? "R3 gated vector" : "R2 bypass vector", req_gated, VEC[i][3:0]);
      check("R7 cpu readback", {1'b0, cpu_prio}, {1'b0, VEC[i][22:20]});
    end

    // R8: write one channel, others unchanged (state: cpu1, p=2,1,0,2)
    wr(3, 3'd0); // ch1 from 1 to 0, still masked
    wr(4, 3'd5); // ch2 from 0 to 5 -> passes
    req_raw = 4'hF; #1;
    check("R8 only written channels change", req_gated, 4'hD);

    // R9: same-cycle propagation
    @(negedge clk);
    req_raw = 4'h1; #1;
    check("R9 same-cycle drop", req_gated, 4'h1);
    #2;
    req_raw = 4'h4; #1;
    check("R9 same-cycle change", req_gated, 4'h4);

    // R4: mode 0 tracking, enable+auto
    irq_mode = 1'b0;
    imask = 3'b001;
    wr(0, 3'b011);
    @(negedge clk); #1;
    check("R4 mask bit 1 -> level 4", {1'b0, cpu_prio}, 4'h4);
    wr(2, 3'd5); wr(3, 3'd4); wr(4, 3'd3); wr(5, 3'd7);
    req_raw = 4'hF; #1;
    check("R4 gating at level 4", req_gated, 4'h9);
    imask = 3'b110;
    @(negedge clk); #1;
    check("R4 mask bit 0 -> level 0", {1'b0, cpu_prio}, 4'h0);

    // R6: writes ignored under auto-update
    wr(1, 3'd7);
    @(negedge clk); #1;
    check("R6 write ignored in auto", {1'b0, cpu_prio}, 4'h0);
    check("R6 gating unaffected", req_gated, 4'hF);

    // R5: mode 2 tracking
    irq_mode = 1'b1;
    imask = 3'd5;
    @(negedge clk); #1;
    check("R5 follows mask 5", {1'b0, cpu_prio}, 4'h5);
    check("R5 gating at level 5", req_gated, 4'h8);
    imask = 3'd2;
    @(negedge clk); #1;
    check("R5 follows mask 2", {1'b0, cpu_prio}, 4'h2);

    // R7: auto off keeps last value, ignores mask
    wr(0, 3'b001);
    imask = 3'd7;
    repeat (3) @(negedge clk);
    #1;
    check("R7 held after auto off", {1'b0, cpu_prio}, 4'h2);
    wr(1, 3'd6);
    #1;
    check("R7 software write loads", {1'b0, cpu_prio}, 4'h6);
    check("R3 gating at level 6", req_gated, 4'h8);

    finish_run();
  end
endmodule